// File: doc/BRIEF.md
# Trace Byte Packer

The trace byte packer turns a trace message into a byte stream. The message arrives one field at a time. Each field is a value of up to 64 bits, and a flag says whether that field closes the message. The block cuts each field into 6-bit chunks, starting with the lowest chunk. It does not send high chunks that are zero. Each chunk goes out in one byte, with a 2-bit control code in the lowest bits. The code marks a normal byte, the end of a field, or the end of the whole message.

Output bytes come out one per cycle with no gaps. When no field is pending, the block sends the idle byte (all ones). The upstream source presents fields with a valid/ready handshake. The block holds one field at a time. It can take the next field during the cycle that shows the last byte of the current field, so a message streams without holes.

Top module: `trace_byte_packer`

## Requirements
- R1: Each output byte has the 6 data bits of one chunk in bits 7:2 and the control code in bits 1:0.
- R2: Chunks of a field go out lowest first: byte k of a field carries field bits 6k+5 down to 6k.
- R3: High chunks that are all zero are not sent. A field of 0xFFE goes out as exactly two bytes, 0xF8 then 0xFF when it ends the message.
- R4: A field whose value is zero still goes out as one byte with zero data bits and the proper end code (0x01 or 0x03).
- R5: The control code is 00 on every byte except the last one of a field. The last byte carries 01 if more fields of the message follow, and 11 if the field ends the message.
- R6: From the second clock edge after reset, byteValid is high on every cycle. Whenever no field is being sent, byteOut is 0xFF.
- R7: fieldReady is low while the current field still has more than the byte now on the output. It is high when idle and during the last byte of a field, so consecutive fields follow with no idle byte between them.
- R8: While reset is asserted, byteValid is low and fieldReady is high.
- R9: A field with its top bit set takes eleven bytes. The last of those bytes holds field bits 63:60 in data bits 3:0, and data bits 5:4 of that byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fieldValid | input | 1 | A field is presented |
| fieldData | input | 64 | Field value, bit 0 sent first |
| msgLast | input | 1 | The presented field is the last of its message |
| fieldReady | output | 1 | The field is taken on this edge if fieldValid is high |
| byteOut | output | 8 | Output byte: data in 7:2, control code in 1:0 |
| byteValid | output | 1 | byteOut carries a stream byte (data or idle) |

## Verification
A wrong chunk count or a stale remaining-byte counter shows up as a missing, extra or misplaced end code. A wrong counter can also hold fieldReady low for too long, which delays or merges the next field. Either fault reaches the byte stream within the field in progress, at most eleven cycles after the field is taken. The scoreboard compares every output cycle against the expected stream, idle bytes included. Any misplaced byte, wrong code, wrong ready level or inserted gap is therefore caught in the cycle where it first appears.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // control-to-datapath strobes and control status
  typedef struct packed {
    logic load;      // take a new field into the shift register
    logic advance;   // move to the next chunk
    logic busy;      // a field is being sent
    logic lastByte;  // current byte is the final chunk of its field
    logic endMsg;    // current field closes the message
  } tbp_strobe_t;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_NORMAL    = 2'b00;
  localparam logic [CODE_W-1:0] CODE_FIELD_END = 2'b01;
  localparam logic [CODE_W-1:0] CODE_MSG_END   = 2'b11;

endpackage

// File: rtl/tbp_datapath.sv
module tbp_datapath
  import tbp_pkg::*;
#(
  parameter int FIELD_W = 64,
  parameter int CHUNK_W = 6,
  localparam int CHUNKS = (FIELD_W + CHUNK_W - 1) / CHUNK_W,
  localparam int PAD_W  = CHUNKS * CHUNK_W,
  localparam int CNT_W  = $clog2(CHUNKS + 1),
  localparam int BYTE_W = CHUNK_W + CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] fieldData,
  input  tbp_strobe_t        strobe,
  output logic [CNT_W-1:0]   chunkCount,
  output logic [BYTE_W-1:0]  byteOut
);

  logic [PAD_W-1:0]  paddedIn;
  logic [PAD_W-1:0]  shiftReg;
  logic [CODE_W-1:0] codeNow;

  assign paddedIn = PAD_W'(fieldData);

  // number of chunks up to and including the highest non-zero one, at least one
  always_comb begin
    chunkCount = CNT_W'(1);
    for (int i = 1; i < CHUNKS; i++) begin
      if (paddedIn[i*CHUNK_W +: CHUNK_W] != '0) chunkCount = CNT_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= paddedIn;
    end else if (strobe.advance) begin
      shiftReg <= shiftReg >> CHUNK_W;
    end
  end

  always_comb begin
    if (!strobe.lastByte)   codeNow = CODE_NORMAL;
    else if (strobe.endMsg) codeNow = CODE_MSG_END;
    else                    codeNow = CODE_FIELD_END;
  end

  assign byteOut = strobe.busy ? {shiftReg[CHUNK_W-1:0], codeNow} : '1;

endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fieldValid,
  input  logic             msgLast,
  input  logic [CNT_W-1:0] chunkCount,
  output logic             fieldReady,
  output logic             byteValid,
  output tbp_strobe_t      strobe
);

  logic             busy;
  logic [CNT_W-1:0] remaining;
  logic             endMsgQ;
  logic             validQ;
  logic             lastByte;
  logic             accept;

  assign lastByte   = busy && (remaining == CNT_W'(1));
  assign fieldReady = !busy || lastByte;
  assign accept     = fieldValid && fieldReady;
  assign byteValid  = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      endMsgQ   <= 1'b0;
      validQ    <= 1'b0;
    end else begin
      validQ <= 1'b1;
      if (accept) begin
        busy      <= 1'b1;
        remaining <= chunkCount;
        endMsgQ   <= msgLast;
      end else if (busy) begin
        if (lastByte) busy <= 1'b0;
        remaining <= remaining - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.advance  = busy && !accept;
    strobe.busy     = busy;
    strobe.lastByte = lastByte;
    strobe.endMsg   = endMsgQ;
  end

endmodule

// File: rtl/trace_byte_packer.sv
module trace_byte_packer
  import tbp_pkg::*;
#(
  parameter int FIELD_W = 64,
  parameter int CHUNK_W = 6,
  localparam int CHUNKS = (FIELD_W + CHUNK_W - 1) / CHUNK_W,
  localparam int CNT_W  = $clog2(CHUNKS + 1),
  localparam int BYTE_W = CHUNK_W + CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fieldValid,
  input  logic [FIELD_W-1:0] fieldData,
  input  logic               msgLast,
  output logic               fieldReady,
  output logic [BYTE_W-1:0]  byteOut,
  output logic               byteValid
);

  tbp_strobe_t      strobe;
  logic [CNT_W-1:0] chunkCount;

  tbp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .fieldValid (fieldValid),
    .msgLast    (msgLast),
    .chunkCount (chunkCount),
    .fieldReady (fieldReady),
    .byteValid  (byteValid),
    .strobe     (strobe)
  );

  tbp_datapath #(.FIELD_W(FIELD_W), .CHUNK_W(CHUNK_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .fieldData  (fieldData),
    .strobe     (strobe),
    .chunkCount (chunkCount),
    .byteOut    (byteOut)
  );

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fieldValid,
  input logic              fieldReady,
  input logic [BYTE_W-1:0] byteOut,
  input logic              byteValid,
  input logic              busy,
  input logic              lastByte
);

  // R6: no field in flight means the idle pattern
  a_r6_idle_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !busy) |-> (byteOut == '1));

  // R6: the strobe stays high once out of reset
  a_r6_valid_steady: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> byteValid);

  // R7: no new field is taken while more than one byte remains
  a_r7_ready_held_low: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastByte) |-> !fieldReady);

  // R5: the final byte of a field carries an end code
  a_r5_end_code_on_last: assert property (@(posedge clk) disable iff (!rstN)
    lastByte |-> (byteOut[1:0] != 2'b00));

  // R5: a normal-coded byte is always followed by more of the same field
  a_r5_normal_continues: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteOut[1:0] == 2'b00) |=> busy);

  // R7: an accepted field starts on the very next cycle
  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (fieldValid && fieldReady) |=> busy);

endmodule

bind trace_byte_packer tbp_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .fieldValid (fieldValid),
  .fieldReady (fieldReady),
  .byteOut    (byteOut),
  .byteValid  (byteValid),
  .busy       (strobe.busy),
  .lastByte   (strobe.lastByte)
);

// File: tb/trace_byte_packer_tb.sv
`timescale 1ns/1ps
module trace_byte_packer_tb_top;

  typedef struct {
    logic [7:0] b;
    string      req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fieldValid = 1'b0;
  logic [63:0] fieldData = '0;
  logic        msgLast = 1'b0;
  logic        fieldReady;
  logic [7:0]  byteOut;
  logic        byteValid;

  int    nChecks = 0;
  int    nFails = 0;
  item_t expQ[$];
  bit    monOn = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  trace_byte_packer dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .fieldValid (fieldValid),
    .fieldData  (fieldData),
    .msgLast    (msgLast),
    .fieldReady (fieldReady),
    .byteOut    (byteOut),
    .byteValid  (byteValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // driver: present one field, push its expected bytes once it is taken
  task automatic sendField(input logic [63:0] d, input bit last, input string req);
    logic [65:0] pad;
    int          top;
    int          n;
    @(negedge clk);
    fieldValid = 1'b1;
    fieldData  = d;
    msgLast    = last;
    while (!fieldReady) @(negedge clk);
    @(posedge clk);
    #1;
    fieldValid = 1'b0;
    pad = {2'b00, d};
    top = 0;
    for (int k = 63; k >= 0; k--) begin
      if (d[k]) begin
        top = k;
        break;
      end
    end
    n = top / 6 + 1;
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic [1:0] code;
      code = (i != n - 1) ? 2'b00 : (last ? 2'b11 : 2'b01);
      it.b   = {pad[i*6 +: 6], code};
      it.req = req;
      expQ.push_back(it);
    end
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every cycle is either the next expected byte or idle
  initial begin
    wait (monOn);
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        check(fieldReady == (expQ.size() <= 1), "R7", "fieldReady",
              64'(fieldReady), 64'(expQ.size() <= 1));
        it = expQ.pop_front();
        check(byteValid && byteOut == it.b, it.req, "byteOut",
              {55'd0, byteValid, byteOut}, {55'd0, 1'b1, it.b});
      end else begin
        check(byteValid && byteOut == 8'hFF, "R6", "idle byte",
              {55'd0, byteValid, byteOut}, {55'd0, 1'b1, 8'hFF});
        check(fieldReady, "R7", "ready when idle", 64'(fieldReady), 64'd1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(!byteValid, "R8", "byteValid in reset", 64'(byteValid), 64'd0);
    check(fieldReady, "R8", "fieldReady in reset", 64'(fieldReady), 64'd1);
    rstN = 1'b1;
    @(posedge clk);
    monOn = 1'b1;
    idleCycles(4);

    // R3: 12-bit value with a dropped empty chunk count
    sendField(64'hFFE, 1'b1, "R3");
    sendField(64'h3F, 1'b1, "R3");
    idleCycles(3);

    // R4: zero-valued fields, inside and at end of message
    sendField(64'h0, 1'b0, "R4");
    sendField(64'h0, 1'b1, "R4");
    idleCycles(2);

    // R2 and R5: three-field message with ordered chunks and codes
    sendField(64'h123, 1'b0, "R2");
    sendField(64'h0, 1'b0, "R5");
    sendField(64'hABCDEF, 1'b1, "R5");
    idleCycles(2);

    // R9: full-width fields
    sendField(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R9");
    sendField(64'h8000_0000_0000_0000, 1'b0, "R9");
    sendField(64'h1, 1'b1, "R1");
    idleCycles(5);  // R6: idle stream

    // R1: mixed widths, back to back
    for (int m = 0; m < 40; m++) begin
      logic [63:0] d;
      d = {$urandom, $urandom} >> $urandom_range(0, 63);
      sendField(d, ($urandom_range(0, 2) == 0), "R1");
      if ($urandom_range(0, 3) == 0) idleCycles($urandom_range(1, 3));
    end

    while (expQ.size() > 0) @(negedge clk);
    idleCycles(4);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule